// File: doc/BRIEF.md
# One-Time-Programmable Memory Programming Controller

This block is the device-side controller of a one-time-programmable memory while it sits in programming mode. Three level-sensitive strobes (`ce`, `oe`, `pgm`) are sampled on the clock and decoded into a handful of modes. In these modes the block collects a four-entry page of address/data pairs, burns either that page or a single byte into the cell array, reads a cell back for verification, or leaves the data bus floating.

The cells behave like fuses. An unprogrammed bit reads as 1, and a program operation can only clear bits, so a cell takes the AND of its old value and the written byte. Only the lower part of the address space can be programmed. Cells above `LAST_ADDR` are never written.

The bidirectional data bus is split into `din`, `dout` and a drive enable `dout_en`, which a pad ring turns into a tri-state pin. Programming mode is active only while `hv_ok` is high and `ext_reset` is low.

Top module: `otp_prog_ctrl`

## Requirements
- R1: No cell is written and `dout_en` stays low unless `hv_ok` = 1 and `ext_reset` = 0.
- R2: After reset every cell reads 8'hFF.
- R3: Verify mode (`ce`=0, `oe`=0, `pgm`=1) drives the byte stored at `addr` on `dout` with `dout_en`=1, two clock edges after the inputs are applied.
- R4: `dout_en` is 0 whenever `oe`=1, and whenever `ce`=1, whatever the other strobes are.
- R5: Byte write: a falling edge of `pgm` while `ce`=0 and `oe`=1 sets the cell at `addr` to old AND `din`.
- R6: Page latch: while `ce`=1 and `pgm`=1, each falling edge of `oe` stores (`addr`, `din`) into the next of 4 page entries. After entry 3 the index wraps to entry 0, so a fifth strobe overwrites the first pair.
- R7: Page write: a falling edge of `pgm` while `ce`=1 and `oe`=1 programs every page entry latched since the last page write (old AND data), then empties the page.
- R8: The page index returns to entry 0 whenever `ce` or `pgm` goes low.
- R9: While `pgm` stays high, no cell changes, whatever happens on `ce`, `oe`, `addr` and `din`.
- R10: A write to an address above `LAST_ADDR` has no effect, and such cells keep reading 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hv_ok | input | 1 | High programming voltage present |
| ext_reset | input | 1 | Device reset pin level; must be low to program |
| ce | input | 1 | Chip enable strobe |
| oe | input | 1 | Output enable strobe, active low |
| pgm | input | 1 | Program strobe, active-low pulse |
| addr | input | ADDR_W | Cell address |
| din | input | 8 | Data bus, inbound |
| dout | output | 8 | Data bus, outbound |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
The bench builds the block with `ADDR_W` = 6 and `LAST_ADDR` = 59. This makes the array 64 cells, so every cell can be swept in the erased, byte-written and page-written states. The four cells above the programmable limit fall inside the same sweeps. The page is kept at four entries, which puts the wrap-around and the index restart within a few strobes. Two successive patterns are written over the whole array, which shows that the AND rule only ever clears bits.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_IDLE,
    MODE_LATCH,
    MODE_VERIFY,
    MODE_PULSE
  } prog_mode_e;
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hv_ok,
  input  logic              ext_reset,
  input  logic              ce,
  input  logic              oe,
  input  logic              pgm,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] din_q,
  output logic              sess,
  output logic              latch_stb,
  output logic              page_go,
  output logic              byte_go,
  output logic              vfy
);
  logic en_q, ce_q, oe_q, pgm_q, oe_p, pgm_p, pulse;
  prog_mode_e mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      ce_q   <= 1'b1;
      oe_q   <= 1'b1;
      pgm_q  <= 1'b1;
      oe_p   <= 1'b1;
      pgm_p  <= 1'b1;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      en_q   <= hv_ok & ~ext_reset;
      ce_q   <= ce;
      oe_q   <= oe;
      pgm_q  <= pgm;
      oe_p   <= oe_q;
      pgm_p  <= pgm_q;
      addr_q <= addr;
      din_q  <= din;
    end
  end

  always_comb begin
    if (!en_q)                          mode = MODE_OFF;
    else if (!pgm_q)                    mode = MODE_PULSE;
    else if (ce_q && !oe_q)             mode = MODE_LATCH;
    else if (!ce_q && !oe_q)            mode = MODE_VERIFY;
    else                                mode = MODE_IDLE;
  end

  assign sess      = en_q & ce_q & pgm_q;
  assign latch_stb = (mode == MODE_LATCH) & oe_p;
  assign pulse     = (mode == MODE_PULSE) & pgm_p & oe_q;
  assign page_go   = pulse & ce_q;
  assign byte_go   = pulse & ~ce_q;
  assign vfy       = (mode == MODE_VERIFY);
endmodule

// File: rtl/otp_page_buf.sv
module otp_page_buf
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_N = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sess,
  input  logic              latch_stb,
  input  logic              page_go,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] din_q,
  output logic              busy,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int IW = (PAGE_N > 1) ? $clog2(PAGE_N) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(PAGE_N - 1);

  logic [ADDR_W-1:0] pa [PAGE_N];
  logic [DATA_W-1:0] pd [PAGE_N];
  logic [PAGE_N-1:0] valid;
  logic [IW-1:0]     idx, walk;
  logic              take;

  assign take = sess & latch_stb & ~busy;

  always_ff @(posedge clk) begin
    if (take) begin
      pa[idx] <= addr_q;
      pd[idx] <= din_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      walk  <= '0;
      valid <= '0;
      busy  <= 1'b0;
    end else begin
      if (busy) begin
        walk <= walk + 1'b1;
        if (walk == LAST_IDX) begin
          busy  <= 1'b0;
          valid <= '0;
        end
      end else if (page_go) begin
        busy <= 1'b1;
        walk <= '0;
      end
      if (!sess) begin
        idx <= '0;
      end else if (take) begin
        valid[idx] <= 1'b1;
        idx        <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
      end
    end
  end

  assign wr_req  = busy & valid[walk];
  assign wr_addr = pa[walk];
  assign wr_data = pd[walk];

  // R7
  page_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (valid == '0));
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_prog_pkg::*;
#(
  parameter int          ADDR_W    = 10,
  parameter int unsigned LAST_ADDR = 32'h3BF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              in_range;

  assign in_range = (32'(wr_addr) <= LAST_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      rd_data <= '1;
    end else begin
      if (wr_req && in_range) mem[wr_addr] <= mem[wr_addr] & wr_data;
      rd_data <= mem[rd_addr];
    end
  end

  logic              chk_v, chk_oor;
  logic [ADDR_W-1:0] chk_a;
  logic [DATA_W-1:0] chk_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_v   <= 1'b0;
      chk_oor <= 1'b0;
      chk_a   <= '0;
      chk_old <= '1;
    end else begin
      chk_v   <= wr_req & in_range;
      chk_oor <= wr_req & ~in_range;
      chk_a   <= wr_addr;
      chk_old <= mem[wr_addr];
    end
  end

  // R5
  bits_clear_chk: assert property (@(posedge clk) disable iff (rst)
    chk_v |-> ((mem[chk_a] & ~chk_old) == '0));

  // R10
  range_chk: assert property (@(posedge clk) disable iff (rst)
    chk_oor |-> (mem[chk_a] == '1));
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_prog_pkg::*;
#(
  parameter int          ADDR_W    = 10,
  parameter int unsigned LAST_ADDR = 32'h3BF,
  parameter int          PAGE_N    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hv_ok,
  input  logic              ext_reset,
  input  logic              ce,
  input  logic              oe,
  input  logic              pgm,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);
  logic [ADDR_W-1:0] addr_q, pb_addr, wa;
  logic [DATA_W-1:0] din_q, pb_data, wd;
  logic sess, latch_stb, page_go, byte_go, vfy, busy, pb_req, we;

  otp_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .hv_ok(hv_ok), .ext_reset(ext_reset),
    .ce(ce), .oe(oe), .pgm(pgm), .addr(addr), .din(din),
    .addr_q(addr_q), .din_q(din_q), .sess(sess), .latch_stb(latch_stb),
    .page_go(page_go), .byte_go(byte_go), .vfy(vfy)
  );

  otp_page_buf #(.ADDR_W(ADDR_W), .PAGE_N(PAGE_N)) u_page (
    .clk(clk), .rst(rst), .sess(sess), .latch_stb(latch_stb),
    .page_go(page_go), .addr_q(addr_q), .din_q(din_q), .busy(busy),
    .wr_req(pb_req), .wr_addr(pb_addr), .wr_data(pb_data)
  );

  assign we = pb_req | (byte_go & ~busy);
  assign wa = busy ? pb_addr : addr_q;
  assign wd = busy ? pb_data : din_q;

  otp_cell_array #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_cells (
    .clk(clk), .rst(rst), .wr_req(we), .wr_addr(wa), .wr_data(wd),
    .rd_addr(addr_q), .rd_data(dout)
  );

  always_ff @(posedge clk) begin
    if (rst) dout_en <= 1'b0;
    else     dout_en <= vfy;
  end

  // R1
  prog_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!hv_ok || ext_reset) |-> !(byte_go || page_go || latch_stb));

  // R4
  hiz_chk: assert property (@(posedge clk) disable iff (rst)
    $past(oe || ce, 2) |-> !dout_en);
endmodule

// File: tb/sim_otp_prog_ctrl.sv
module sim_otp_prog_ctrl;
  localparam int AW   = 6;
  localparam int LAST = 59;
  localparam int N    = 1 << AW;

  logic clk = 1'b0, rst = 1'b1, hv_ok = 1'b0, ext_reset = 1'b1;
  logic ce = 1'b1, oe = 1'b1, pgm = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic dout_en;
  logic [7:0] exp_mem [N];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  otp_prog_ctrl #(.ADDR_W(AW), .LAST_ADDR(LAST), .PAGE_N(4)) u0 (
    .clk(clk), .rst(rst), .hv_ok(hv_ok), .ext_reset(ext_reset),
    .ce(ce), .oe(oe), .pgm(pgm), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic void model_wr(input int a, input logic [7:0] d);
    if (a <= LAST) exp_mem[a] = exp_mem[a] & d;
  endfunction

  task automatic read_chk(input string req, input int a);
    ce = 1'b0; oe = 1'b0; pgm = 1'b1; addr = AW'(a);
    tick(2);
    check(req, {dout_en, dout}, {1'b1, exp_mem[a]});
    oe = 1'b1;
    tick(1);
  endtask

  task automatic byte_wr(input int a, input logic [7:0] d);
    ce = 1'b0; oe = 1'b1; pgm = 1'b1; addr = AW'(a); din = d;
    tick(2);
    pgm = 1'b0;
    tick(2);
    pgm = 1'b1;
    tick(2);
  endtask

  task automatic latch_one(input int a, input logic [7:0] d);
    ce = 1'b1; pgm = 1'b1; oe = 1'b1; addr = AW'(a); din = d;
    tick(1);
    oe = 1'b0;
    tick(2);
    oe = 1'b1;
    tick(1);
  endtask

  task automatic page_fire();
    ce = 1'b1; oe = 1'b1; pgm = 1'b0;
    tick(2);
    pgm = 1'b1;
    tick(8);
  endtask

  initial begin
    for (int i = 0; i < N; i++) exp_mem[i] = 8'hFF;
    tick(4);
    // reset state
    check("R4 reset", {8'h00, dout_en}, 9'h000);
    rst = 1'b0;
    tick(2);
    // R1: outside programming mode nothing is driven or written
    ce = 1'b0; oe = 1'b0; pgm = 1'b1; addr = 6'd3;
    tick(3);
    check("R1 no drive off-mode", {8'h00, dout_en}, 9'h000);
    byte_wr(3, 8'h00);
    hv_ok = 1'b1; ext_reset = 1'b0;
    tick(2);
    read_chk("R1 write off-mode ignored", 3);
    hv_ok = 1'b0;
    byte_wr(4, 8'h00);
    hv_ok = 1'b1; ext_reset = 1'b1;
    byte_wr(5, 8'h00);
    ext_reset = 1'b0;
    tick(2);
    read_chk("R1 low hv ignored", 4);
    read_chk("R1 reset high ignored", 5);
    // R2: erased sweep
    for (int a = 0; a < N; a++) read_chk("R2 erased", a);
    // R4: float in other modes
    ce = 1'b0; oe = 1'b1; pgm = 1'b1; tick(3);
    check("R4 oe high", {8'h00, dout_en}, 9'h000);
    ce = 1'b1; oe = 1'b0; pgm = 1'b1; tick(3);
    check("R4 ce high", {8'h00, dout_en}, 9'h000);
    ce = 1'b1; oe = 1'b0; pgm = 1'b0; tick(3);
    check("R4 standby", {8'h00, dout_en}, 9'h000);
    pgm = 1'b1; oe = 1'b1; tick(2);
    // R5 / R10: byte write sweep
    for (int a = 0; a < N; a++) begin
      logic [7:0] d;
      d = 8'hC0 | 8'(a);
      byte_wr(a, d);
      model_wr(a, d);
    end
    for (int a = 0; a < N; a++) read_chk("R5 R10 byte sweep", a);
    // R7 / R3: page write sweep, reversed order in each page
    for (int p = 0; p < N / 4; p++) begin
      for (int k = 3; k >= 0; k--) begin
        int a;
        logic [7:0] d;
        a = p * 4 + k;
        d = 8'h80 | 8'(a ^ 6'h2A);
        latch_one(a, d);
        model_wr(a, d);
      end
      page_fire();
    end
    for (int a = 0; a < N; a++) read_chk("R7 R3 page sweep", a);
    // R9: pgm held high, strobes toggling
    ce = 1'b0; oe = 1'b1; pgm = 1'b1; addr = 6'd10; din = 8'h00;
    tick(3);
    ce = 1'b1; tick(2); oe = 1'b0; tick(2); oe = 1'b1; ce = 1'b0; tick(3);
    read_chk("R9 inhibit", 10);
    // R6: five strobes in one session, fifth overwrites entry 0
    latch_one(20, 8'h00);
    latch_one(21, 8'h00);
    latch_one(22, 8'h00);
    latch_one(23, 8'h00);
    latch_one(24, 8'h00);
    page_fire();
    model_wr(21, 8'h00); model_wr(22, 8'h00);
    model_wr(23, 8'h00); model_wr(24, 8'h00);
    for (int a = 20; a <= 24; a++) read_chk("R6 wrap", a);
    // R8: index restarts when ce drops
    latch_one(30, 8'h00);
    latch_one(31, 8'h00);
    ce = 1'b0; tick(3);
    latch_one(32, 8'h00);
    page_fire();
    model_wr(31, 8'h00); model_wr(32, 8'h00);
    for (int a = 30; a <= 32; a++) read_chk("R8 restart", a);
    // R7: page empties after write; a bare pulse commits nothing
    page_fire();
    read_chk("R7 page emptied", 33);
    // R10: page write above limit
    latch_one(62, 8'h00);
    page_fire();
    read_chk("R10 page high", 62);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule